// File: doc/BRIEF.md
# Key Event Queue

This block holds up to sixteen key events for a keyboard matrix of eight columns by eight rows, which gives 64 keys. A debouncer that is already in place presents one event at a time on the push side: a column index, a row index, and a kind (press, release or repeat). The block turns the column and row into a key number, drops release events when releases are switched off, and stores the rest in arrival order.

On the read side the host pulses a read strobe. Each strobe loads one status byte into an output register. That byte carries the oldest event and also says whether more events follow, so a host can drain the queue by polling alone.

Several byte values do double duty. The empty code, the overflow code and the repeat codes share the bit patterns of keys 62 and 63. For those two keys the "more follows" bit is forced high, so after reading one of them the host must read again to learn whether anything is left. When an event arrives at a full queue it is lost. The next read then reports the loss once, and later reads go on with the stored events.

Top module: `key_event_queue`

## Requirements
- R1: After a synchronous reset the read byte is 0x3F and the queue holds no events.
- R2: A stored press or release reads with key number column*8+row in bits [5:0]. Bit 6 reads 1 for a release and 0 for a press. The kind input encodes press as 2'b00, release as 2'b01 and repeat as 2'b10; the code 2'b11 stores nothing.
- R3: For keys 0 to 61, bit 7 of the read byte is 1 when at least one more event remains after the one being read, and 0 when the one being read is the last.
- R4: Key 62 reads 0xBE on a press and 0xFE on a release. Key 63 reads 0xBF on a press and 0xFF on a release. These four values hold whether or not more events remain.
- R5: A repeat event ignores column and row. It reads 0x3E when it is the last stored event and 0x7E when more events follow.
- R6: A read strobe on an empty queue with no pending overflow loads 0x3F and removes nothing.
- R7: A release event is stored only while the release-enable input is 1. Press and repeat events are stored regardless of that input.
- R8: The queue holds 16 events. An accepted event that arrives while 16 are stored, in a cycle with no removal, is dropped and sets a pending overflow.
- R9: A read strobe while an overflow is pending loads 0x7F, clears the pending overflow and removes nothing. Later reads return the stored events in arrival order.
- R10: A read strobe on a non-empty queue with no pending overflow removes exactly the oldest event. The read byte changes only on a clock edge that samples the strobe high.
- R11: If a push and a removing read occur in the same cycle on a full queue, the pushed event is stored and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Push strobe for one debounced event |
| evt_kind | input | 2 | Event kind: 00 press, 01 release, 10 repeat, 11 none |
| evt_col | input | 3 | Column index of the key |
| evt_row | input | 3 | Row index of the key |
| rel_en | input | 1 | Accept release events when 1 |
| rd_req | input | 1 | Read strobe, one event per strobe |
| rd_byte | output | 8 | Registered status byte from the most recent read |

## Verification
Push and read both act on the same rising edge that samples their strobes. The read byte for a strobe therefore appears one edge after the strobe is driven, and a pushed event can be read with the strobe in the very next cycle. The bench drives inputs on the falling edge and updates a behavioural queue model once per rising edge. It compares the read byte a few nanoseconds after that edge, and it compares every cycle, so a byte that changes without a strobe is caught in the cycle it changes. The overflow report is due exactly on the first strobe after the drop. The simultaneous push and read on a full queue is checked through the contents that later reads return.

// File: rtl/keq_pkg.sv
package keq_pkg;

    localparam int COL_W = 3;
    localparam int ROW_W = 3;
    localparam int KEY_W = COL_W + ROW_W;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        EV_PRESS   = 2'b00,
        EV_RELEASE = 2'b01,
        EV_REPEAT  = 2'b10,
        EV_NONE    = 2'b11
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e           kind;
        logic [KEY_W-1:0]   key;
    } ev_entry_t;

    localparam logic [BYTE_W-1:0] CODE_EMPTY       = 8'h3F;
    localparam logic [BYTE_W-1:0] CODE_OVERFLOW    = 8'h7F;
    localparam logic [BYTE_W-1:0] CODE_REPEAT_LAST = 8'h3E;
    localparam logic [BYTE_W-1:0] CODE_REPEAT_MORE = 8'h7E;

    // lowest key number whose slot collides with a status code
    localparam logic [KEY_W-1:0] KEY_SHARED_LO = 6'd62;

    function automatic logic [KEY_W-1:0] key_index(
        input logic [COL_W-1:0] col,
        input logic [ROW_W-1:0] row
    );
        return {col, row};
    endfunction

    function automatic logic is_shared_key(input logic [KEY_W-1:0] key);
        return key >= KEY_SHARED_LO;
    endfunction

endpackage

// File: rtl/keq_admit.sv
module keq_admit
    import keq_pkg::*;
(
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [COL_W-1:0]  evt_col,
    input  logic [ROW_W-1:0]  evt_row,
    input  logic              rel_en,
    output logic              adm_valid,
    output ev_entry_t         adm_entry
);

    ev_kind_e kind;

    always_comb begin
        kind = ev_kind_e'(evt_kind);
        adm_entry.kind = kind;
        if (kind == EV_REPEAT) begin
            adm_entry.key = '1;
        end else begin
            adm_entry.key = key_index(evt_col, evt_row);
        end
        unique case (kind)
            EV_PRESS:   adm_valid = evt_valid;
            EV_RELEASE: adm_valid = evt_valid && rel_en;
            EV_REPEAT:  adm_valid = evt_valid;
            default:    adm_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/keq_ring.sv
module keq_ring
    import keq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  ev_entry_t         wr_data,
    output ev_entry_t         head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    ev_entry_t          mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W-1:0]   wr_ptr_nx;
    logic [PTR_W-1:0]   rd_ptr_nx;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_ptr_nx = wr_ptr + 1'b1;
            assign rd_ptr_nx = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr_nx;
            end
            if (pop) begin
                rd_ptr <= rd_ptr_nx;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/keq_format.sv
module keq_format
    import keq_pkg::*;
(
    input  ev_entry_t          head,
    input  logic               more,
    output logic [BYTE_W-1:0]  code
);

    always_comb begin
        if (head.kind == EV_REPEAT) begin
            code = more ? CODE_REPEAT_MORE : CODE_REPEAT_LAST;
        end else begin
            code[KEY_W-1:0] = head.key;
            code[6]         = (head.kind == EV_RELEASE);
            code[7]         = more | is_shared_key(head.key);
        end
    end

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import keq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_valid,
    input  logic [1:0]          evt_kind,
    input  logic [COL_W-1:0]    evt_col,
    input  logic [ROW_W-1:0]    evt_row,
    input  logic                rel_en,
    input  logic                rd_req,
    output logic [BYTE_W-1:0]   rd_byte
);

    logic               adm_valid;
    ev_entry_t          adm_entry;
    ev_entry_t          head;
    logic [CNT_W-1:0]   count;
    logic               full;
    logic               empty;
    logic               pop;
    logic               push_ok;
    logic               ovf_q;
    logic [BYTE_W-1:0]  ev_code;
    logic [BYTE_W-1:0]  rd_byte_q;

    keq_admit u_admit (
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_col   (evt_col),
        .evt_row   (evt_row),
        .rel_en    (rel_en),
        .adm_valid (adm_valid),
        .adm_entry (adm_entry)
    );

    assign pop     = rd_req && !ovf_q && !empty;
    assign push_ok = adm_valid && (!full || pop);

    keq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .push    (push_ok),
        .pop     (pop),
        .wr_data (adm_entry),
        .head    (head),
        .count   (count),
        .full    (full),
        .empty   (empty)
    );

    keq_format u_format (
        .head (head),
        .more (count > CNT_W'(1)),
        .code (ev_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q     <= 1'b0;
            rd_byte_q <= CODE_EMPTY;
        end else begin
            if (adm_valid && !push_ok) begin
                ovf_q <= 1'b1;
            end else if (rd_req && ovf_q) begin
                ovf_q <= 1'b0;
            end
            if (rd_req) begin
                if (ovf_q) begin
                    rd_byte_q <= CODE_OVERFLOW;
                end else if (empty) begin
                    rd_byte_q <= CODE_EMPTY;
                end else begin
                    rd_byte_q <= ev_code;
                end
            end
        end
    end

    assign rd_byte = rd_byte_q;

endmodule

// File: rtl/keq_checker.sv
module keq_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic              rel_en,
    input logic              rd_req,
    input logic [7:0]        rd_byte,
    input logic [CNT_W-1:0]  count,
    input logic              full,
    input logic              empty,
    input logic              ovf_q,
    input logic              pop,
    input logic              push_ok,
    input logic              adm_valid
);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        adm_valid && full && !pop |=> ovf_q && count == CNT_W'(DEPTH)); // R8

    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        rd_req && !empty && !ovf_q |=>
        int'(count) == int'($past(count)) - 1 + int'($past(push_ok))); // R10

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_byte)); // R10

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req && empty && !ovf_q |=> rd_byte == 8'h3F); // R6

    AST_OVF_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req && ovf_q |=> rd_byte == 8'h7F && int'(count) >= int'($past(count))); // R9

    AST_REL_FILTER: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_kind == 2'b01 && !rel_en |=>
        int'(count) == int'($past(count)) - int'($past(pop))); // R7

endmodule

bind key_event_queue keq_checker #(.DEPTH(DEPTH)) u_keq_checker (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .rel_en    (rel_en),
    .rd_req    (rd_req),
    .rd_byte   (rd_byte),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .ovf_q     (ovf_q),
    .pop       (pop),
    .push_ok   (push_ok),
    .adm_valid (adm_valid)
);

// File: tb/tb_key_event_queue.sv
module tb_key_event_queue;

    logic       clk = 1'b0;
    logic       rst;
    logic       evt_valid;
    logic [1:0] evt_kind;
    logic [2:0] evt_col;
    logic [2:0] evt_row;
    logic       rel_en;
    logic       rd_req;
    logic [7:0] rd_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state: entries are kind*64 + key
    int  mq[$];
    bit  m_ovf;
    int  m_byte;

    always #10 clk = ~clk;

    key_event_queue dut (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_col   (evt_col),
        .evt_row   (evt_row),
        .rel_en    (rel_en),
        .rd_req    (rd_req),
        .rd_byte   (rd_byte)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run exceeded cycle budget");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int fmt(int e, bit more);
        int k;
        int key;
        k   = e / 64;
        key = e % 64;
        if (k == 2) return more ? 8'h7E : 8'h3E;
        if (key >= 62) return 128 + (k == 1 ? 64 : 0) + key;
        return (more ? 128 : 0) + (k == 1 ? 64 : 0) + key;
    endfunction

    task automatic check(string tag, int expv);
        checks++;
        if (int'(rd_byte) != expv) begin
            errors++;
            $display("FAIL %s: rd_byte=%02h expected=%02h", tag, rd_byte, expv[7:0]);
        end
    endtask

    task automatic cyc(bit v, int k, int c, int r, bit rd, string tag);
        bit adm;
        bit popping;
        @(negedge clk);
        evt_valid = v;
        evt_kind  = 2'(k);
        evt_col   = 3'(c);
        evt_row   = 3'(r);
        rd_req    = rd;
        @(posedge clk);
        adm     = v && (k == 0 || k == 2 || (k == 1 && rel_en));
        popping = rd && !m_ovf && mq.size() > 0;
        if (rd) begin
            if (m_ovf) m_byte = 8'h7F;
            else if (mq.size() == 0) m_byte = 8'h3F;
            else m_byte = fmt(mq[0], mq.size() > 1);
        end
        if (rd && m_ovf) m_ovf = 1'b0;
        if (popping) void'(mq.pop_front());
        if (adm) begin
            if (mq.size() < 16) mq.push_back(k * 64 + (k == 2 ? 63 : c * 8 + r));
            else m_ovf = 1'b1;
        end
        #3;
        check(tag, m_byte);
    endtask

    task automatic drain(string tag);
        while (mq.size() > 0 || m_ovf) cyc(0, 0, 0, 0, 1, tag);
        cyc(0, 0, 0, 0, 1, tag);
    endtask

    initial begin
        rst = 1'b1; evt_valid = 0; evt_kind = 0; evt_col = 0; evt_row = 0;
        rel_en = 0; rd_req = 0; m_ovf = 0; m_byte = 8'h3F;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 check("R1 reset byte", 8'h3F);
        cyc(0, 0, 0, 0, 1, "R1 empty after reset");
        cyc(0, 0, 0, 0, 1, "R6 empty read");

        // R2 key number: col 2 row 5 -> key 21
        cyc(1, 0, 2, 5, 0, "R2 push press");
        cyc(0, 0, 0, 0, 0, "R10 hold without read");
        cyc(0, 0, 0, 0, 1, "R2 press byte 0x15");
        // R7 release filtered when disabled
        cyc(1, 1, 2, 5, 0, "R7 release dropped");
        cyc(0, 0, 0, 0, 1, "R7 queue stays empty");
        rel_en = 1;
        cyc(1, 1, 2, 5, 0, "R7 release accepted");
        cyc(0, 0, 0, 0, 1, "R2 release byte 0x55");
        // kind 11 stores nothing
        cyc(1, 3, 4, 4, 0, "R2 none kind");
        cyc(0, 0, 0, 0, 1, "R2 none kind not stored");

        // R3 more flag
        cyc(1, 0, 0, 0, 0, "R3 push key0");
        cyc(1, 0, 1, 1, 0, "R3 push key9");
        cyc(1, 1, 7, 5, 0, "R3 push key61 release");
        drain("R3 more flag");

        // R4 shared keys, alone and followed by more
        cyc(1, 0, 7, 6, 0, "R4 push 62 press");
        drain("R4 key62 press");
        cyc(1, 1, 7, 6, 0, "R4 push 62 release");
        drain("R4 key62 release");
        cyc(1, 0, 7, 7, 0, "R4 push 63 press");
        cyc(1, 1, 7, 7, 0, "R4 push 63 release");
        cyc(1, 0, 3, 3, 0, "R4 push trailer");
        drain("R4 key63 codes");

        // R5 repeat
        cyc(1, 2, 5, 5, 0, "R5 push repeat");
        drain("R5 repeat last");
        cyc(1, 2, 0, 0, 0, "R5 push repeat");
        cyc(1, 0, 6, 1, 0, "R5 push press");
        drain("R5 repeat more");

        // R8/R9 overflow
        for (int i = 0; i < 18; i++) cyc(1, i % 2, i / 8, i % 8, 0, "R8 fill");
        drain("R9 overflow then data");

        // R11 simultaneous push and read on full queue
        for (int i = 0; i < 16; i++) cyc(1, 0, 2 + i / 8, i % 8, 0, "R11 fill");
        cyc(1, 0, 7, 0, 1, "R11 push with read");
        cyc(1, 0, 7, 1, 0, "R8 push on full");
        cyc(0, 0, 0, 0, 1, "R9 overflow code");
        cyc(1, 2, 0, 0, 1, "R10 push repeat while reading");
        drain("R11 contents");

        // push and read in the same cycle on an empty queue
        cyc(1, 0, 1, 2, 1, "R6 read empty while pushing");
        drain("R10 pushed event readable");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule